// File: doc/BRIEF.md
# Byte-Parity Multiport Cache Data Array

This block is the data store of a first-level data cache: 16 KB held as four ways of 4 KB. Each way is 512 words of 64 bits, and every data byte carries its own even-parity bit, so the array holds 2 KB of check bits next to the data. Two load ports each read one 64-bit word from a chosen way and word index in the same cycle. Two store ports each write any subset of the eight bytes of a word under a byte mask. A fill port writes a whole 64-byte line (eight consecutive words) into one way in a single cycle.

Parity is generated on every write path and checked on every load. Each load returns an 8-bit error mask that flags the bytes whose stored parity does not match. Because parity is per byte, a partial store never needs to read the old word. Store port 0 has a parity-invert mask that lets a test plant bad parity on the bytes it writes. This is the only way to drive the checker from the ports.

Per cycle the write side takes one of three named operations. IDLE means no write. STORE means one or both store ports write. FILL means a line write, which drops both store ports for that cycle. The word index is split as index[8:3] = line within the way and index[2:0] = word within the line.

Top module: `l1_data_array`

## Requirements
- R1: While reset is held, and in the first cycle after it, both load ports show valid low with data and error mask at zero. Data and error mask also read zero in any cycle where valid is low.
- R2: A load request (enable high, way, 9-bit word index) raises that port's valid in the next cycle, carrying the 64-bit word stored at that way and index.
- R3: A store writes byte b of its data (bits 8b+7..8b) only where mask bit b is 1. Bytes whose mask bit is 0 keep their old value and old parity.
- R4: The two store ports write independently in the same cycle, to different words or ways.
- R5: When both store ports write the same byte of the same word in one cycle, the store port 1 byte is kept. Bytes written by only one port take that port's value.
- R6: A fill writes fill-data bits 64k+63..64k into word k of the addressed line (index = {line, k}) of the chosen way, for k = 0..7.
- R7: In a cycle with a fill request, both store ports are ignored. Their target words keep their previous contents, whatever way they address.
- R8: Parity is even. Error mask bit b is 1 exactly when byte b and its parity bit together hold an odd number of ones. Normally written data reads back with a zero mask.
- R9: Setting bit b of store port 0's parity-invert input, with mask bit b set, stores an inverted parity bit for byte b. Later loads flag byte b until the byte is written again.
- R10: A load to a word written in the same cycle returns the old contents. A load in the next cycle returns the new contents.
- R11: The two load ports read independently in the same cycle, including the same word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld0_en | input | 1 | Load port 0 request |
| ld0_way | input | 2 | Load port 0 way |
| ld0_addr | input | 9 | Load port 0 word index |
| ld0_valid | output | 1 | Load port 0 result valid |
| ld0_data | output | 64 | Load port 0 word |
| ld0_perr | output | 8 | Load port 0 per-byte parity error |
| ld1_en | input | 1 | Load port 1 request |
| ld1_way | input | 2 | Load port 1 way |
| ld1_addr | input | 9 | Load port 1 word index |
| ld1_valid | output | 1 | Load port 1 result valid |
| ld1_data | output | 64 | Load port 1 word |
| ld1_perr | output | 8 | Load port 1 per-byte parity error |
| st0_en | input | 1 | Store port 0 request |
| st0_way | input | 2 | Store port 0 way |
| st0_addr | input | 9 | Store port 0 word index |
| st0_mask | input | 8 | Store port 0 byte enables |
| st0_data | input | 64 | Store port 0 data |
| st0_par_flip | input | 8 | Store port 0 per-byte parity invert |
| st1_en | input | 1 | Store port 1 request |
| st1_way | input | 2 | Store port 1 way |
| st1_addr | input | 9 | Store port 1 word index |
| st1_mask | input | 8 | Store port 1 byte enables |
| st1_data | input | 64 | Store port 1 data |
| fill_en | input | 1 | Line fill request |
| fill_way | input | 2 | Fill way |
| fill_line | input | 6 | Fill line within way |
| fill_data | input | 512 | Fill line, word k at bits 64k+63..64k |

## Verification
First every line of every way is filled with a word pattern that encodes its way and index, and both ports read it back. This separates way, line and word-within-line decoding. Directed stores then try single-byte, edge-byte, sparse and full masks, followed by two-port stores to distinct words, to disjoint bytes of one word and to overlapping bytes. These cases separate mask handling from port priority. A fill placed in the same cycle as stores shows the stores are dropped. Same-cycle load-and-store shows the old word is read, and planted parity inversions show which bytes the checker flags and when they clear. A long random mix confined to a few words per way forces frequent collisions between all five ports.

// File: rtl/dary_pkg.sv
package dary_pkg;
    typedef enum logic [1:0] {
        WOP_IDLE  = 2'd0,
        WOP_STORE = 2'd1,
        WOP_FILL  = 2'd2
    } wop_e;

    localparam int NUM_LD = 2;
    localparam int NUM_ST = 2;
endpackage

// File: rtl/dary_pgen.sv
module dary_pgen #(
    parameter int NBYTES = 8
) (
    input  logic [8*NBYTES-1:0] data,
    input  logic [NBYTES-1:0]   flip,
    output logic [NBYTES-1:0]   par
);
    for (genvar b = 0; b < NBYTES; b++) begin : g_byte
        assign par[b] = (^data[8*b +: 8]) ^ flip[b];
    end
endmodule

// File: rtl/dary_wctl.sv
module dary_wctl
    import dary_pkg::*;
#(
    parameter int NWAYS = 4,
    localparam int WW = (NWAYS > 1) ? $clog2(NWAYS) : 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NUM_ST-1:0]            st_en,
    input  logic [NUM_ST-1:0][WW-1:0]    st_way,
    input  logic                         fill_en,
    input  logic [WW-1:0]                fill_way,
    output logic [NWAYS-1:0]             way_fill_we,
    output logic [NWAYS-1:0][NUM_ST-1:0] way_st_we
);
    wop_e op;

    always_comb begin
        if (fill_en)       op = WOP_FILL;
        else if (|st_en)   op = WOP_STORE;
        else               op = WOP_IDLE;
    end

    always_comb begin
        way_fill_we = '0;
        way_st_we   = '0;
        unique case (op)
            WOP_IDLE: ;
            WOP_FILL: way_fill_we[fill_way] = 1'b1;
            WOP_STORE: begin
                for (int p = 0; p < NUM_ST; p++)
                    if (st_en[p]) way_st_we[st_way[p]][p] = 1'b1;
            end
            default: ;
        endcase
    end

    assert_fill_blocks_stores_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fill_en |-> (way_st_we == '0));

    assert_fill_one_way_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(way_fill_we) && (fill_en == (way_fill_we != '0)));
endmodule

// File: rtl/dary_way.sv
module dary_way
    import dary_pkg::*;
#(
    parameter int WORDS      = 512,
    parameter int BYTES      = 8,
    parameter int LINE_WORDS = 8,
    localparam int DW  = 8*BYTES,
    localparam int EW  = DW + BYTES,
    localparam int AW  = $clog2(WORDS),
    localparam int LW  = $clog2(LINE_WORDS),
    localparam int LAW = AW - LW
) (
    input  logic                          clk,
    input  logic                          fill_we,
    input  logic [LAW-1:0]                fill_line,
    input  logic [LINE_WORDS*DW-1:0]      fill_data,
    input  logic [LINE_WORDS*BYTES-1:0]   fill_par,
    input  logic [NUM_ST-1:0]             st_we,
    input  logic [NUM_ST-1:0][AW-1:0]     st_addr,
    input  logic [NUM_ST-1:0][BYTES-1:0]  st_mask,
    input  logic [NUM_ST-1:0][DW-1:0]     st_data,
    input  logic [NUM_ST-1:0][BYTES-1:0]  st_par,
    input  logic [NUM_LD-1:0]             rd_en,
    input  logic [NUM_LD-1:0][AW-1:0]     rd_addr,
    output logic [NUM_LD-1:0][EW-1:0]     rd_q
);
    // entry layout: parity bits above data bits
    logic [EW-1:0] mem [WORDS];

    always_ff @(posedge clk) begin
        for (int p = 0; p < NUM_LD; p++)
            if (rd_en[p]) rd_q[p] <= mem[rd_addr[p]];
    end

    always_ff @(posedge clk) begin
        if (fill_we) begin
            for (int k = 0; k < LINE_WORDS; k++)
                mem[{fill_line, LW'(k)}] <= {fill_par[k*BYTES +: BYTES], fill_data[k*DW +: DW]};
        end else begin
            // later port overrides earlier on shared bytes
            for (int p = 0; p < NUM_ST; p++) begin
                if (st_we[p]) begin
                    for (int b = 0; b < BYTES; b++) begin
                        if (st_mask[p][b]) begin
                            mem[st_addr[p]][8*b +: 8] <= st_data[p][8*b +: 8];
                            mem[st_addr[p]][DW+b]     <= st_par[p][b];
                        end
                    end
                end
            end
        end
    end
endmodule

// File: rtl/dary_rport.sv
module dary_rport #(
    parameter int NWAYS = 4,
    parameter int BYTES = 8,
    localparam int DW = 8*BYTES,
    localparam int EW = DW + BYTES,
    localparam int WW = (NWAYS > 1) ? $clog2(NWAYS) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      en,
    input  logic [WW-1:0]             way,
    input  logic [NWAYS-1:0][EW-1:0]  way_q,
    output logic                      valid,
    output logic [DW-1:0]             data,
    output logic [BYTES-1:0]          perr
);
    logic          valid_q;
    logic [WW-1:0] way_r;
    logic [EW-1:0] sel;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            way_r   <= '0;
        end else begin
            valid_q <= en;
            if (en) way_r <= way;
        end
    end

    assign sel   = way_q[way_r];
    assign valid = valid_q;
    assign data  = valid_q ? sel[DW-1:0] : '0;

    for (genvar b = 0; b < BYTES; b++) begin : g_chk
        assign perr[b] = valid_q & ((^sel[8*b +: 8]) ^ sel[DW+b]);
    end

    assert_load_valid_next_R2: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> valid);

    assert_no_spurious_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !valid);

    assert_quiet_when_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |-> (data == '0 && perr == '0));
endmodule

// File: rtl/l1_data_array.sv
module l1_data_array
    import dary_pkg::*;
#(
    parameter int NWAYS      = 4,
    parameter int WAY_WORDS  = 512,
    parameter int WORD_BYTES = 8,
    parameter int LINE_WORDS = 8,
    localparam int DW  = 8*WORD_BYTES,
    localparam int EW  = DW + WORD_BYTES,
    localparam int AW  = $clog2(WAY_WORDS),
    localparam int WW  = (NWAYS > 1) ? $clog2(NWAYS) : 1,
    localparam int LW  = $clog2(LINE_WORDS),
    localparam int LAW = AW - LW,
    localparam int FW  = DW*LINE_WORDS
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ld0_en,
    input  logic [WW-1:0]         ld0_way,
    input  logic [AW-1:0]         ld0_addr,
    output logic                  ld0_valid,
    output logic [DW-1:0]         ld0_data,
    output logic [WORD_BYTES-1:0] ld0_perr,
    input  logic                  ld1_en,
    input  logic [WW-1:0]         ld1_way,
    input  logic [AW-1:0]         ld1_addr,
    output logic                  ld1_valid,
    output logic [DW-1:0]         ld1_data,
    output logic [WORD_BYTES-1:0] ld1_perr,
    input  logic                  st0_en,
    input  logic [WW-1:0]         st0_way,
    input  logic [AW-1:0]         st0_addr,
    input  logic [WORD_BYTES-1:0] st0_mask,
    input  logic [DW-1:0]         st0_data,
    input  logic [WORD_BYTES-1:0] st0_par_flip,
    input  logic                  st1_en,
    input  logic [WW-1:0]         st1_way,
    input  logic [AW-1:0]         st1_addr,
    input  logic [WORD_BYTES-1:0] st1_mask,
    input  logic [DW-1:0]         st1_data,
    input  logic                  fill_en,
    input  logic [WW-1:0]         fill_way,
    input  logic [LAW-1:0]        fill_line,
    input  logic [FW-1:0]         fill_data
);
    logic [NUM_ST-1:0][WW-1:0]         st_way;
    logic [NUM_ST-1:0][AW-1:0]         st_addr;
    logic [NUM_ST-1:0][WORD_BYTES-1:0] st_mask;
    logic [NUM_ST-1:0][DW-1:0]         st_data;
    logic [NUM_ST-1:0][WORD_BYTES-1:0] st_flip;
    logic [NUM_ST-1:0][WORD_BYTES-1:0] st_par;
    logic [FW/8-1:0]                   fill_par;
    logic [NWAYS-1:0]                  way_fill_we;
    logic [NWAYS-1:0][NUM_ST-1:0]      way_st_we;
    logic [NUM_LD-1:0]                 rd_en;
    logic [NUM_LD-1:0][AW-1:0]         rd_addr;
    logic [NUM_LD-1:0][WW-1:0]         rd_way;
    logic [NUM_LD-1:0][NWAYS-1:0][EW-1:0] port_q;
    logic [NWAYS-1:0][NUM_LD-1:0][EW-1:0] way_rd_q;
    logic [NUM_LD-1:0]                 ld_valid;
    logic [NUM_LD-1:0][DW-1:0]         ld_data;
    logic [NUM_LD-1:0][WORD_BYTES-1:0] ld_perr;

    assign st_way  = {st1_way,  st0_way};
    assign st_addr = {st1_addr, st0_addr};
    assign st_mask = {st1_mask, st0_mask};
    assign st_data = {st1_data, st0_data};
    assign st_flip = {{WORD_BYTES{1'b0}}, st0_par_flip};
    assign rd_en   = {ld1_en,   ld0_en};
    assign rd_addr = {ld1_addr, ld0_addr};
    assign rd_way  = {ld1_way,  ld0_way};

    for (genvar p = 0; p < NUM_ST; p++) begin : g_stpar
        dary_pgen #(.NBYTES(WORD_BYTES)) u_pgen (
            .data (st_data[p]),
            .flip (st_flip[p]),
            .par  (st_par[p])
        );
    end

    dary_pgen #(.NBYTES(FW/8)) u_fill_pgen (
        .data (fill_data),
        .flip ('0),
        .par  (fill_par)
    );

    dary_wctl #(.NWAYS(NWAYS)) u_wctl (
        .clk         (clk),
        .rst_n       (rst_n),
        .st_en       ({st1_en, st0_en}),
        .st_way      (st_way),
        .fill_en     (fill_en),
        .fill_way    (fill_way),
        .way_fill_we (way_fill_we),
        .way_st_we   (way_st_we)
    );

    for (genvar w = 0; w < NWAYS; w++) begin : g_way
        dary_way #(
            .WORDS(WAY_WORDS), .BYTES(WORD_BYTES), .LINE_WORDS(LINE_WORDS)
        ) u_way (
            .clk       (clk),
            .fill_we   (way_fill_we[w]),
            .fill_line (fill_line),
            .fill_data (fill_data),
            .fill_par  (fill_par),
            .st_we     (way_st_we[w]),
            .st_addr   (st_addr),
            .st_mask   (st_mask),
            .st_data   (st_data),
            .st_par    (st_par),
            .rd_en     (rd_en),
            .rd_addr   (rd_addr),
            .rd_q      (way_rd_q[w])
        );
    end

    for (genvar p = 0; p < NUM_LD; p++) begin : g_ld
        for (genvar w = 0; w < NWAYS; w++) begin : g_gather
            assign port_q[p][w] = way_rd_q[w][p];
        end
        dary_rport #(.NWAYS(NWAYS), .BYTES(WORD_BYTES)) u_rport (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (rd_en[p]),
            .way   (rd_way[p]),
            .way_q (port_q[p]),
            .valid (ld_valid[p]),
            .data  (ld_data[p]),
            .perr  (ld_perr[p])
        );
    end

    assign ld0_valid = ld_valid[0];
    assign ld0_data  = ld_data[0];
    assign ld0_perr  = ld_perr[0];
    assign ld1_valid = ld_valid[1];
    assign ld1_data  = ld_data[1];
    assign ld1_perr  = ld_perr[1];

    assert_same_slot_same_result_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (ld0_en && ld1_en && ld0_way == ld1_way && ld0_addr == ld1_addr)
        |=> (ld0_data == ld1_data && ld0_perr == ld1_perr));
endmodule

// File: tb/l1_data_array_test.sv
module l1_data_array_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic        ld_en [2];
    logic [1:0]  ld_way [2];
    logic [8:0]  ld_addr [2];
    logic        ld_valid [2];
    logic [63:0] ld_data [2];
    logic [7:0]  ld_perr [2];
    logic        st_en [2];
    logic [1:0]  st_way [2];
    logic [8:0]  st_addr [2];
    logic [7:0]  st_mask [2];
    logic [63:0] st_data [2];
    logic [7:0]  flip;
    logic        fill_en;
    logic [1:0]  fill_way;
    logic [5:0]  fill_line;
    logic [511:0] fill_data;

    l1_data_array uut (
        .clk(clk), .rst_n(rst_n),
        .ld0_en(ld_en[0]), .ld0_way(ld_way[0]), .ld0_addr(ld_addr[0]),
        .ld0_valid(ld_valid[0]), .ld0_data(ld_data[0]), .ld0_perr(ld_perr[0]),
        .ld1_en(ld_en[1]), .ld1_way(ld_way[1]), .ld1_addr(ld_addr[1]),
        .ld1_valid(ld_valid[1]), .ld1_data(ld_data[1]), .ld1_perr(ld_perr[1]),
        .st0_en(st_en[0]), .st0_way(st_way[0]), .st0_addr(st_addr[0]),
        .st0_mask(st_mask[0]), .st0_data(st_data[0]), .st0_par_flip(flip),
        .st1_en(st_en[1]), .st1_way(st_way[1]), .st1_addr(st_addr[1]),
        .st1_mask(st_mask[1]), .st1_data(st_data[1]),
        .fill_en(fill_en), .fill_way(fill_way), .fill_line(fill_line),
        .fill_data(fill_data)
    );

    // behavioural reference: flat word array, index = way*512 + word
    logic [63:0] m_d [0:2047];
    logic [7:0]  m_p [0:2047];
    logic        ev [2];
    logic [63:0] ed [2];
    logic [7:0]  ee [2];
    int nvec = 0;
    int nfail = 0;
    int cyc = 0;
    string tag = "R1";

    function automatic logic [7:0] par8(input logic [63:0] d);
        logic [7:0] r;
        for (int b = 0; b < 8; b++) r[b] = ^d[8*b +: 8];
        return r;
    endfunction

    function automatic logic [63:0] pat(input int way, input int idx, input int salt);
        return {16'(way), 16'(idx), 32'(salt * 32'h9E37_79B9 + idx)};
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int p = 0; p < 2; p++) begin ev[p] = 0; ed[p] = 0; ee[p] = 0; end
        end else begin
            for (int p = 0; p < 2; p++) begin
                ev[p] = ld_en[p];
                if (ld_en[p]) begin
                    ed[p] = m_d[ld_way[p]*512 + ld_addr[p]];
                    ee[p] = par8(ed[p]) ^ m_p[ld_way[p]*512 + ld_addr[p]];
                end else begin
                    ed[p] = 0; ee[p] = 0;
                end
            end
            if (fill_en) begin
                for (int k = 0; k < 8; k++) begin
                    m_d[fill_way*512 + fill_line*8 + k] = fill_data[64*k +: 64];
                    m_p[fill_way*512 + fill_line*8 + k] = par8(fill_data[64*k +: 64]);
                end
            end else begin
                for (int p = 0; p < 2; p++) begin
                    if (st_en[p]) begin
                        for (int b = 0; b < 8; b++) begin
                            if (st_mask[p][b]) begin
                                m_d[st_way[p]*512 + st_addr[p]][8*b +: 8] = st_data[p][8*b +: 8];
                                m_p[st_way[p]*512 + st_addr[p]][b] =
                                    (^st_data[p][8*b +: 8]) ^ ((p == 0) ? flip[b] : 1'b0);
                            end
                        end
                    end
                end
            end
        end
    end

    task automatic idle();
        for (int p = 0; p < 2; p++) begin
            ld_en[p] = 0; ld_way[p] = 0; ld_addr[p] = 0;
            st_en[p] = 0; st_way[p] = 0; st_addr[p] = 0; st_mask[p] = 0; st_data[p] = 0;
        end
        flip = 0; fill_en = 0; fill_way = 0; fill_line = 0; fill_data = '0;
    endtask

    task automatic tick();
        @(negedge clk);
        for (int p = 0; p < 2; p++) begin
            nvec++;
            if (ld_valid[p] !== ev[p] || ld_data[p] !== ed[p] || ld_perr[p] !== ee[p]) begin
                nfail++;
                $display("FAIL %s port%0d valid/data/perr got %b/%h/%h expected %b/%h/%h",
                         tag, p, ld_valid[p], ld_data[p], ld_perr[p], ev[p], ed[p], ee[p]);
            end
        end
        idle();
    endtask

    task automatic load(input int p, input int w, input int a);
        ld_en[p] = 1; ld_way[p] = 2'(w); ld_addr[p] = 9'(a);
    endtask

    task automatic store(input int p, input int w, input int a, input logic [7:0] m,
                         input logic [63:0] d);
        st_en[p] = 1; st_way[p] = 2'(w); st_addr[p] = 9'(a); st_mask[p] = m; st_data[p] = d;
    endtask

    task automatic fill(input int w, input int line, input int salt);
        fill_en = 1; fill_way = 2'(w); fill_line = 6'(line);
        for (int k = 0; k < 8; k++) fill_data[64*k +: 64] = pat(w, line*8 + k, salt);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            nfail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    end

    initial begin
        idle();
        tag = "R1";
        tick(); tick();
        rst_n = 1;
        tick();

        tag = "R6";
        for (int w = 0; w < 4; w++)
            for (int l = 0; l < 64; l++) begin fill(w, l, 1); tick(); end

        tag = "R2 R6 R11";
        for (int i = 0; i < 2048; i += 7) begin
            load(0, i / 512, i % 512);
            load(1, (i / 512) ^ 3, (i * 13) % 512);
            tick();
        end
        tick();

        tag = "R11";
        load(0, 2, 77); load(1, 2, 77); tick(); tick();

        tag = "R3";
        store(0, 1, 40, 8'h01, 64'h1111_2222_3333_44AA); tick(); load(0, 1, 40); tick();
        store(0, 1, 40, 8'h80, 64'hBB00_0000_0000_0000); tick(); load(0, 1, 40); tick();
        store(1, 3, 511, 8'hA5, 64'hDEAD_BEEF_CAFE_F00D); tick(); load(1, 3, 511); tick();
        store(0, 0, 0, 8'hFF, 64'h0123_4567_89AB_CDEF); tick(); load(0, 0, 0); tick();
        store(1, 0, 0, 8'h00, 64'hFFFF_FFFF_FFFF_FFFF); tick(); load(0, 0, 0); tick();
        tick();

        tag = "R4";
        store(0, 2, 100, 8'hFF, 64'hAAAA_0000_AAAA_0000);
        store(1, 2, 101, 8'hFF, 64'h5555_1111_5555_1111); tick();
        load(0, 2, 100); load(1, 2, 101); tick();
        store(0, 0, 9, 8'h0F, 64'h0); store(1, 3, 9, 8'hF0, 64'h0); tick();
        load(0, 0, 9); load(1, 3, 9); tick(); tick();

        tag = "R5";
        store(0, 1, 200, 8'h0F, 64'h0000_0000_1234_5678);
        store(1, 1, 200, 8'hF0, 64'h9ABC_DEF0_0000_0000); tick();
        load(0, 1, 200); tick();
        store(0, 1, 201, 8'h3C, 64'h1111_1111_1111_1111);
        store(1, 1, 201, 8'h18, 64'h2222_2222_2222_2222); tick();
        load(1, 1, 201); tick(); tick();

        tag = "R7";
        fill(2, 20, 5);
        store(0, 2, 160, 8'hFF, 64'hFFFF_0000_FFFF_0000);
        store(1, 0, 300, 8'hFF, 64'h0000_FFFF_0000_FFFF); tick();
        load(0, 2, 160); load(1, 0, 300); tick();
        load(0, 2, 167); tick(); tick();

        tag = "R10";
        store(0, 3, 50, 8'hFF, 64'h7777_6666_5555_4444); load(0, 3, 50); tick();
        load(1, 3, 50); tick();
        fill(3, 6, 9); load(0, 3, 50); load(1, 3, 49); tick();
        load(0, 3, 50); load(1, 3, 49); tick(); tick();

        tag = "R8 R9";
        store(0, 0, 400, 8'hFF, 64'h0F0F_0F0F_0F0F_0F0F); flip = 8'h0F; tick();
        load(0, 0, 400); load(1, 0, 400); tick();
        store(0, 0, 400, 8'h03, 64'h0000_0000_0000_ABCD); tick();
        load(0, 0, 400); tick();
        store(0, 0, 401, 8'h10, 64'h0); flip = 8'hEF; tick();
        load(1, 0, 401); tick();
        store(1, 0, 401, 8'h10, 64'h0000_00FF_0000_0000); tick();
        load(1, 0, 401); tick();
        fill(0, 50, 3); tick(); load(0, 0, 400); load(1, 0, 401); tick(); tick();

        tag = "R2 R3 R4 R5 R7 R8 R9 R10 R11 mix";
        for (int i = 0; i < 4000; i++) begin
            for (int p = 0; p < 2; p++) begin
                if ($urandom_range(0, 1)) load(p, $urandom_range(0, 3), $urandom_range(0, 15));
                if ($urandom_range(0, 2) == 0)
                    store(p, $urandom_range(0, 3), $urandom_range(0, 15),
                          8'($urandom), {$urandom, $urandom});
            end
            if ($urandom_range(0, 3) == 0) flip = 8'($urandom);
            if ($urandom_range(0, 9) == 0) fill($urandom_range(0, 3), $urandom_range(0, 1), i);
            tick();
        end
        tick();

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end
endmodule